// File: doc/BRIEF.md
# Indexed RTC Register and Interrupt Unit

This block is the register front end of a real-time clock. The host reaches it through two byte-wide ports that are selected by one address line. A write to the even port chooses which of 128 byte locations the odd port reaches next. The odd port then reads or writes that location. Most locations are plain storage. Four control locations (A, B, C, D) hold the update-in-progress status, the interrupt enables and the interrupt flags.

Two strobes from sibling blocks drive the block. The once-per-second update supplies a start pulse and an end pulse, together with the new time-of-day fields. A periodic tick comes from the rate divider. At the end of an update the block copies the new time into its time bytes, unless the host has frozen them. It then compares the seconds, minutes and hours against three alarm bytes and raises flags in register C. One level interrupt stays high until the host reads register C, which also clears the flags.

Top module: `rtc_hostregs`

## Requirements
- R1: An even-port write stores bits 6:0 of the data as the index (bit 7 is dropped). An even-port read returns 0xFF.
- R2: An odd-port write to any index other than 10 to 13 stores the byte, and a later odd-port read at that index returns it. This covers the time bytes (0, 2, 4, 6, 7, 8, 9) and the alarm bytes (1 seconds, 3 minutes, 5 hours).
- R3: A write to register A (index 10) replaces bits 6:0. Bit 7 (UIP) keeps its value.
- R4: Writes to register C (index 12) and register D (index 13) have no effect.
- R5: An odd-port read of register C returns the flags. In the following cycle C reads 0x00 and the interrupt is low.
- R6: A write to register B (index 11) with bit 7 (freeze) set stores the data with bit 4 forced to 0 and clears UIP.
- R7: An update-start pulse sets UIP only while B bit 7 is 0. An update-end pulse clears UIP.
- R8: An update-end pulse sets C bit 4. If B bit 4 is set, it also sets C bit 7 and raises the interrupt.
- R9: At update end, if B bit 5 is set and all three alarm bytes match, C is ORed with 0xA0 and the interrupt rises. An alarm byte matches when it equals its time field, or when both of its bits 7 and 6 are 1.
- R10: A periodic tick with B bit 6 set ORs 0xC0 into C and raises the interrupt. With B bit 6 clear the tick changes nothing.
- R11: After reset A=0x26, B=0x02, C=0x00, D=0x80, the index is 0 and the interrupt is low.
- R12: At update end the time bytes take the new time-of-day fields only while B bit 7 is 0. While B bit 7 is 1 they keep their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_odd | input | 1 | 1 selects the data port, 0 the index port |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe (one cycle per read) |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Host read data, combinational from the current index |
| upd_start | input | 1 | Start of the once-per-second update |
| upd_end | input | 1 | End of the update; the time fields are valid |
| per_tick | input | 1 | Periodic rate tick |
| tod_sec | input | 8 | New seconds field |
| tod_min | input | 8 | New minutes field |
| tod_hour | input | 8 | New hours field |
| tod_wday | input | 8 | New day-of-week field |
| tod_mday | input | 8 | New day-of-month field |
| tod_mon | input | 8 | New month field |
| tod_year | input | 8 | New year field |
| irq | output | 1 | Level interrupt |

## Verification
The embedded assertions check four things on every cycle:
- UIP never stands while the freeze bit is set.
- A read of register C leaves the flags and the interrupt cleared.
- A rising interrupt always follows an update end or a tick.
- Register C and the UIP bit hold steady under host writes that must not touch them.

Other behaviour only the bench scenarios can show. That covers the alarm wildcard and mismatch cases, the frozen time bytes across an update, the index masking, and the restore of the reset values after flags and enables were set. In those scenarios every read and every interrupt level is compared against a behavioural model.

// File: rtl/rtc_regs_pkg.sv
package rtc_regs_pkg;
    localparam int BYTE_W      = 8;
    localparam int IDX_W       = 7;
    localparam int STORE_DEPTH = 1 << IDX_W;
    localparam int TIME_FIELDS = 7;
    localparam int ALARM_FIELDS = 3;

    // Index map: alarm bytes sit right after their time field.
    localparam logic [IDX_W-1:0] IDX_SEC   = 7'd0;
    localparam logic [IDX_W-1:0] IDX_ASEC  = 7'd1;
    localparam logic [IDX_W-1:0] IDX_MIN   = 7'd2;
    localparam logic [IDX_W-1:0] IDX_AMIN  = 7'd3;
    localparam logic [IDX_W-1:0] IDX_HOUR  = 7'd4;
    localparam logic [IDX_W-1:0] IDX_AHOUR = 7'd5;
    localparam logic [IDX_W-1:0] IDX_WDAY  = 7'd6;
    localparam logic [IDX_W-1:0] IDX_MDAY  = 7'd7;
    localparam logic [IDX_W-1:0] IDX_MON   = 7'd8;
    localparam logic [IDX_W-1:0] IDX_YEAR  = 7'd9;
    localparam logic [IDX_W-1:0] IDX_CA    = 7'd10;
    localparam logic [IDX_W-1:0] IDX_CB    = 7'd11;
    localparam logic [IDX_W-1:0] IDX_CC    = 7'd12;
    localparam logic [IDX_W-1:0] IDX_CD    = 7'd13;

    // Bit positions inside the control registers
    localparam int A_UIP  = 7;
    localparam int B_FRZ  = 7;
    localparam int B_PIE  = 6;
    localparam int B_AIE  = 5;
    localparam int B_UIE  = 4;
    localparam int C_IRQF = 7;
    localparam int C_PF   = 6;
    localparam int C_AF   = 5;
    localparam int C_UF   = 4;

    localparam logic [BYTE_W-1:0] RST_A = 8'h26;
    localparam logic [BYTE_W-1:0] RST_B = 8'h02;
    localparam logic [BYTE_W-1:0] RST_D = 8'h80;
    localparam logic [BYTE_W-1:0] B_FRZ_MASK = ~(8'(1) << B_UIE);

    typedef struct packed {
        logic [BYTE_W-1:0] year;
        logic [BYTE_W-1:0] mon;
        logic [BYTE_W-1:0] mday;
        logic [BYTE_W-1:0] wday;
        logic [BYTE_W-1:0] hour;
        logic [BYTE_W-1:0] min;
        logic [BYTE_W-1:0] sec;
    } tod_t;

    typedef enum logic [2:0] {
        SEL_STORE, SEL_A, SEL_B, SEL_C, SEL_D
    } reg_sel_e;

    typedef struct packed {
        logic wr_a;
        logic wr_b;
        logic wr_store;
        logic rd_c;
    } host_op_t;

    function automatic reg_sel_e decode_index(logic [IDX_W-1:0] i);
        case (i)
            IDX_CA:  return SEL_A;
            IDX_CB:  return SEL_B;
            IDX_CC:  return SEL_C;
            IDX_CD:  return SEL_D;
            default: return SEL_STORE;
        endcase
    endfunction

    function automatic logic [IDX_W-1:0] time_index(int f);
        case (f)
            0: return IDX_SEC;
            1: return IDX_MIN;
            2: return IDX_HOUR;
            3: return IDX_WDAY;
            4: return IDX_MDAY;
            5: return IDX_MON;
            default: return IDX_YEAR;
        endcase
    endfunction

    function automatic logic field_match(logic [BYTE_W-1:0] alm, logic [BYTE_W-1:0] cur);
        return (&alm[BYTE_W-1:BYTE_W-2]) || (alm == cur);
    endfunction
endpackage

// File: rtl/rtc_index_port.sv
module rtc_index_port
    import rtc_regs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_odd,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [IDX_W-1:0] wdata_idx,
    output logic [IDX_W-1:0] idx,
    output reg_sel_e         sel,
    output host_op_t         op
);
    logic [IDX_W-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (rst)
            idx_q <= '0;
        else if (bus_wr && !bus_odd)
            idx_q <= wdata_idx;
    end

    always_comb begin
        sel         = decode_index(idx_q);
        op.wr_a     = bus_wr && bus_odd && (sel == SEL_A);
        op.wr_b     = bus_wr && bus_odd && (sel == SEL_B);
        op.wr_store = bus_wr && bus_odd && (sel == SEL_STORE);
        op.rd_c     = bus_rd && bus_odd && (sel == SEL_C);
    end

    assign idx = idx_q;

    assert_index_latch_R1: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !bus_odd) |=> (idx_q == $past(wdata_idx)));
    assert_index_hold_R1: assert property (@(posedge clk) disable iff (rst)
        (!bus_wr || bus_odd) |=> $stable(idx_q));
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp
    import rtc_regs_pkg::*;
(
    input  logic [ALARM_FIELDS-1:0][BYTE_W-1:0] alarm_bytes,
    input  logic [ALARM_FIELDS-1:0][BYTE_W-1:0] cur_fields,
    output logic                                hit
);
    logic [ALARM_FIELDS-1:0] field_hit;

    for (genvar g = 0; g < ALARM_FIELDS; g++) begin : g_field
        assign field_hit[g] = field_match(alarm_bytes[g], cur_fields[g]);
    end

    assign hit = &field_hit;
endmodule

// File: rtl/rtc_byte_store.sv
module rtc_byte_store
    import rtc_regs_pkg::*;
(
    input  logic                                clk,
    input  logic                                rst,
    input  logic [IDX_W-1:0]                    idx,
    input  logic                                wr_en,
    input  logic [BYTE_W-1:0]                   wdata,
    input  logic                                refresh,
    input  tod_t                                tod,
    output logic [BYTE_W-1:0]                   rdata,
    output logic [ALARM_FIELDS-1:0][BYTE_W-1:0] alarm_bytes
);
    logic [BYTE_W-1:0] mem [STORE_DEPTH];
    logic [TIME_FIELDS-1:0][BYTE_W-1:0] tod_bytes;

    assign tod_bytes = tod;

    // A refresh lands after a host write in the same cycle, so it wins.
    always_ff @(posedge clk) begin
        if (wr_en)
            mem[idx] <= wdata;
        if (refresh) begin
            for (int f = 0; f < TIME_FIELDS; f++)
                mem[time_index(f)] <= tod_bytes[f];
        end
    end

    assign rdata          = mem[idx];
    assign alarm_bytes[0] = mem[IDX_ASEC];
    assign alarm_bytes[1] = mem[IDX_AMIN];
    assign alarm_bytes[2] = mem[IDX_AHOUR];

    assert_refresh_sec_R12: assert property (@(posedge clk) disable iff (rst)
        refresh |=> (mem[IDX_SEC] == $past(tod.sec)));
    assert_refresh_year_R12: assert property (@(posedge clk) disable iff (rst)
        refresh |=> (mem[IDX_YEAR] == $past(tod.year)));
endmodule

// File: rtl/rtc_ctrl_regs.sv
module rtc_ctrl_regs
    import rtc_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  host_op_t          op,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              upd_start,
    input  logic              upd_end,
    input  logic              per_tick,
    input  logic              alarm_hit,
    output logic [BYTE_W-1:0] reg_a,
    output logic [BYTE_W-1:0] reg_b,
    output logic [BYTE_W-1:0] reg_c,
    output logic              irq,
    output logic              frozen
);
    logic              uip_q;
    logic [BYTE_W-2:0] a_low_q;
    logic [BYTE_W-1:0] b_q;
    logic [BYTE_W-1:0] c_q;
    logic              irq_q;
    logic              frz_wr;
    logic [BYTE_W-1:0] flag_set;
    logic              raise;

    always_comb begin
        frz_wr   = op.wr_b && wdata[B_FRZ];
        flag_set = '0;
        raise    = 1'b0;
        if (upd_end) begin
            flag_set[C_UF] = 1'b1;
            if (b_q[B_UIE]) begin
                flag_set[C_IRQF] = 1'b1;
                raise            = 1'b1;
            end
            if (b_q[B_AIE] && alarm_hit) begin
                flag_set[C_IRQF] = 1'b1;
                flag_set[C_AF]   = 1'b1;
                raise            = 1'b1;
            end
        end
        if (per_tick && b_q[B_PIE]) begin
            flag_set[C_IRQF] = 1'b1;
            flag_set[C_PF]   = 1'b1;
            raise            = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            uip_q   <= RST_A[A_UIP];
            a_low_q <= RST_A[BYTE_W-2:0];
            b_q     <= RST_B;
            c_q     <= '0;
            irq_q   <= 1'b0;
        end else begin
            if (op.wr_a)
                a_low_q <= wdata[BYTE_W-2:0];
            if (op.wr_b)
                b_q <= frz_wr ? (wdata & B_FRZ_MASK) : wdata;
            if (frz_wr)
                uip_q <= 1'b0;
            else if (upd_start && !b_q[B_FRZ])
                uip_q <= 1'b1;
            else if (upd_end)
                uip_q <= 1'b0;
            c_q   <= (op.rd_c ? '0 : c_q) | flag_set;
            irq_q <= (op.rd_c ? 1'b0 : irq_q) | raise;
        end
    end

    assign reg_a  = {uip_q, a_low_q};
    assign reg_b  = b_q;
    assign reg_c  = c_q;
    assign irq    = irq_q;
    assign frozen = b_q[B_FRZ];

    assert_frozen_no_uip_R6: assert property (@(posedge clk) disable iff (rst)
        b_q[B_FRZ] |-> !uip_q);
    assert_frz_clears_uie_R6: assert property (@(posedge clk) disable iff (rst)
        frz_wr |=> !b_q[B_UIE]);
    assert_uip_kept_R3: assert property (@(posedge clk) disable iff (rst)
        (op.wr_a && !upd_start && !upd_end) |=> $stable(uip_q));
    assert_rdc_clears_R5: assert property (@(posedge clk) disable iff (rst)
        (op.rd_c && !upd_end && !per_tick) |=> (c_q == '0 && !irq_q));
    assert_uf_on_end_R8: assert property (@(posedge clk) disable iff (rst)
        upd_end |=> c_q[C_UF]);
    assert_irq_cause_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_q) |-> $past(upd_end || per_tick));
endmodule

// File: rtl/rtc_hostregs.sv
module rtc_hostregs
    import rtc_regs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_odd,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       upd_start,
    input  logic       upd_end,
    input  logic       per_tick,
    input  logic [7:0] tod_sec,
    input  logic [7:0] tod_min,
    input  logic [7:0] tod_hour,
    input  logic [7:0] tod_wday,
    input  logic [7:0] tod_mday,
    input  logic [7:0] tod_mon,
    input  logic [7:0] tod_year,
    output logic       irq
);
    logic [IDX_W-1:0]  idx;
    reg_sel_e          sel;
    host_op_t          op;
    tod_t              tod;
    logic [BYTE_W-1:0] store_rdata;
    logic [ALARM_FIELDS-1:0][BYTE_W-1:0] alarm_bytes;
    logic [ALARM_FIELDS-1:0][BYTE_W-1:0] cur_fields;
    logic              alarm_hit;
    logic [BYTE_W-1:0] reg_a, reg_b, reg_c;
    logic              frozen;
    logic              refresh;

    assign tod = '{year: tod_year, mon: tod_mon, mday: tod_mday, wday: tod_wday,
                   hour: tod_hour, min: tod_min, sec: tod_sec};
    assign cur_fields = {tod.hour, tod.min, tod.sec};
    assign refresh    = upd_end && !frozen;

    rtc_index_port u_index (
        .clk(clk), .rst(rst), .bus_odd(bus_odd), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .wdata_idx(bus_wdata[IDX_W-1:0]), .idx(idx), .sel(sel), .op(op)
    );

    rtc_byte_store u_store (
        .clk(clk), .rst(rst), .idx(idx), .wr_en(op.wr_store), .wdata(bus_wdata),
        .refresh(refresh), .tod(tod), .rdata(store_rdata), .alarm_bytes(alarm_bytes)
    );

    rtc_alarm_cmp u_alarm (
        .alarm_bytes(alarm_bytes), .cur_fields(cur_fields), .hit(alarm_hit)
    );

    rtc_ctrl_regs u_ctrl (
        .clk(clk), .rst(rst), .op(op), .wdata(bus_wdata), .upd_start(upd_start),
        .upd_end(upd_end), .per_tick(per_tick), .alarm_hit(alarm_hit),
        .reg_a(reg_a), .reg_b(reg_b), .reg_c(reg_c), .irq(irq), .frozen(frozen)
    );

    always_comb begin
        if (!bus_odd)
            bus_rdata = 8'hFF;
        else begin
            case (sel)
                SEL_A:   bus_rdata = reg_a;
                SEL_B:   bus_rdata = reg_b;
                SEL_C:   bus_rdata = reg_c;
                SEL_D:   bus_rdata = RST_D;
                default: bus_rdata = store_rdata;
            endcase
        end
    end

    assert_c_ignores_wr_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_odd && sel == SEL_C && !bus_rd && !upd_end && !per_tick)
        |=> $stable(reg_c));
    assert_b_stable_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_odd && (sel == SEL_C || sel == SEL_D)) |=> $stable(reg_b));
endmodule

// File: tb/rtc_hostregs_tb.sv
module rtc_hostregs_tb;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst = 1'b1;
    logic       bus_odd = 0, bus_wr = 0, bus_rd = 0;
    logic [7:0] bus_wdata = 0;
    logic [7:0] bus_rdata;
    logic       upd_start = 0, upd_end = 0, per_tick = 0;
    logic [7:0] tod_sec = 8'h00, tod_min = 8'h00, tod_hour = 8'h00;
    logic [7:0] tod_wday = 8'h01, tod_mday = 8'h01, tod_mon = 8'h01, tod_year = 8'h00;
    logic       irq;

    rtc_hostregs u_dut (
        .clk(clk), .rst(rst), .bus_odd(bus_odd), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .upd_start(upd_start),
        .upd_end(upd_end), .per_tick(per_tick), .tod_sec(tod_sec), .tod_min(tod_min),
        .tod_hour(tod_hour), .tod_wday(tod_wday), .tod_mday(tod_mday),
        .tod_mon(tod_mon), .tod_year(tod_year), .irq(irq)
    );

    int    checks = 0;
    int    failures = 0;
    bit    done = 0;
    string tag = "R11";

    // Behavioural reference state
    int m_store[128];
    bit m_known[128];
    int m_idx = 0;
    int m_a = 'h26, m_b = 'h02, m_c = 0, m_d = 'h80;
    bit m_irq = 0;

    task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, exp);
        end
    endtask

    function automatic bit alm_ok(int alm, int cur);
        return ((alm & 'hC0) == 'hC0) || (alm == cur);
    endfunction

    task automatic model_step();
        int  cset = 0;
        bit  raise = 0;
        bit  rdc;
        int  ob = m_b;
        bit  uip = (m_a & 'h80) != 0;
        int  tv[7];
        int  ti[7];
        if (rst) begin
            m_a = 'h26; m_b = 'h02; m_c = 0; m_d = 'h80; m_irq = 0; m_idx = 0;
            return;
        end
        tv = '{tod_sec, tod_min, tod_hour, tod_wday, tod_mday, tod_mon, tod_year};
        ti = '{0, 2, 4, 6, 7, 8, 9};
        rdc = bus_rd && bus_odd && (m_idx == 12);
        if (upd_end) begin
            cset |= 'h10;
            if ((ob & 'h10) != 0) begin cset |= 'h80; raise = 1; end
            if ((ob & 'h20) != 0 && alm_ok(m_store[1], tod_sec) &&
                alm_ok(m_store[3], tod_min) && alm_ok(m_store[5], tod_hour)) begin
                cset |= 'hA0; raise = 1;
            end
        end
        if (per_tick && (ob & 'h40) != 0) begin cset |= 'hC0; raise = 1; end
        if (bus_wr && bus_odd && m_idx == 11 && bus_wdata[7]) uip = 0;
        else if (upd_start && (ob & 'h80) == 0) uip = 1;
        else if (upd_end) uip = 0;
        if (bus_wr && bus_odd) begin
            case (m_idx)
                10: m_a = bus_wdata & 'h7F;
                11: m_b = bus_wdata[7] ? (bus_wdata & 'hEF) : bus_wdata;
                12, 13: ;
                default: begin m_store[m_idx] = bus_wdata; m_known[m_idx] = 1; end
            endcase
        end
        if (upd_end && (ob & 'h80) == 0) begin
            for (int f = 0; f < 7; f++) begin
                m_store[ti[f]] = tv[f]; m_known[ti[f]] = 1;
            end
        end
        if (bus_wr && !bus_odd) m_idx = bus_wdata & 'h7F;
        m_a   = (m_a & 'h7F) | (uip ? 'h80 : 0);
        m_c   = (rdc ? 0 : m_c) | cset;
        m_irq = (rdc ? 1'b0 : m_irq) | raise;
    endtask

    function automatic int exp_read(output bit known);
        known = 1;
        if (!bus_odd) return 'hFF;
        case (m_idx)
            10: return m_a;
            11: return m_b;
            12: return m_c;
            13: return m_d;
            default: begin known = m_known[m_idx]; return m_store[m_idx]; end
        endcase
    endfunction

    // One bus cycle; outputs compared with the model away from the clock edge.
    task automatic cyc(bit odd, bit wr, bit rd, int d, bit us = 0, bit ue = 0, bit pt = 0);
        bit kn;
        int e;
        bus_odd = odd; bus_wr = wr; bus_rd = rd; bus_wdata = d[7:0];
        upd_start = us; upd_end = ue; per_tick = pt;
        #1;
        if (!rst) begin
            if (rd) begin
                e = exp_read(kn);
                if (kn) chk("rdata", {24'h0, bus_rdata}, e);
            end
            chk("irq", {31'h0, irq}, {31'h0, m_irq});
        end
        @(posedge clk);
        model_step();
        @(negedge clk);
    endtask

    task automatic set_idx(int i); cyc(0, 1, 0, i); endtask
    task automatic put(int d);     cyc(1, 1, 0, d); endtask
    task automatic get();          cyc(1, 0, 1, 0); endtask
    task automatic rd_at(int i);   set_idx(i); get(); endtask
    task automatic wr_at(int i, int d); set_idx(i); put(d); endtask

    task automatic do_reset(int n);
        rst = 1;
        repeat (n) cyc(0, 0, 0, 0);
        rst = 0;
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset(3);
        // R11: reset values
        tag = "R11";
        rd_at(10); rd_at(11); rd_at(12); rd_at(13);

        // R1: index masking and even-port read
        tag = "R1";
        wr_at('h85, 'h3C);
        rd_at('h05);
        cyc(0, 0, 1, 0);
        // R2: plain storage including the top index
        tag = "R2";
        wr_at('hC0, 'h99); rd_at('h40);
        wr_at('h7F, 'h11); rd_at('h7F);
        wr_at(7, 'h23); rd_at(7);

        // R3: UIP bit survives writes to A
        tag = "R3";
        wr_at(10, 'hFF); get();
        tag = "R7";
        cyc(0, 0, 0, 0, 1, 0, 0);
        rd_at(10);
        tag = "R3";
        put('h26); get();
        tag = "R7";
        cyc(0, 0, 0, 0, 0, 1, 0);
        rd_at(10);

        // R4: C and D ignore writes
        tag = "R4";
        wr_at(12, 'hFF); get();
        tag = "R5";
        get();
        tag = "R4";
        wr_at(13, 'h00); get();

        // R8 / R5: update-ended flag and interrupt, cleared by reading C
        tag = "R8";
        wr_at(11, 'h12);
        cyc(0, 0, 0, 0, 0, 1, 0);
        cyc(0, 0, 0, 0);
        tag = "R5";
        rd_at(12); get(); cyc(0, 0, 0, 0);

        // R6: freeze write forces bit 4 low and clears UIP
        tag = "R6";
        cyc(0, 0, 0, 0, 1, 0, 0);
        rd_at(10);
        wr_at(11, 'h92); get();
        rd_at(10);
        // R7: start pulse ignored while frozen
        tag = "R7";
        cyc(0, 0, 0, 0, 1, 0, 0);
        rd_at(10);
        // R12: time bytes frozen across an update
        tag = "R12";
        tod_sec = 'h45; tod_min = 'h17; tod_hour = 'h09; tod_year = 'h24;
        cyc(0, 0, 0, 0, 0, 1, 0);
        rd_at(0); rd_at(2); rd_at(4); rd_at(9);
        wr_at(11, 'h02);
        cyc(0, 0, 0, 0, 0, 1, 0);
        rd_at(0); rd_at(2); rd_at(4); rd_at(9);
        rd_at(12);

        // R9: alarm match, wildcard, mismatch, disabled
        tag = "R9";
        wr_at(1, 'h45); wr_at(3, 'hC5); wr_at(5, 'h09);
        wr_at(11, 'h22);
        cyc(0, 0, 0, 0, 0, 1, 0);
        cyc(0, 0, 0, 0);
        rd_at(12); cyc(0, 0, 0, 0);
        wr_at(1, 'h46);
        cyc(0, 0, 0, 0, 0, 1, 0);
        cyc(0, 0, 0, 0);
        rd_at(12);
        wr_at(1, 'hFF); wr_at(3, 'h80);
        cyc(0, 0, 0, 0, 0, 1, 0);
        cyc(0, 0, 0, 0);
        rd_at(12);
        wr_at(3, 'hC0); wr_at(11, 'h02);
        cyc(0, 0, 0, 0, 0, 1, 0);
        cyc(0, 0, 0, 0);
        rd_at(12);

        // R10: periodic tick with and without enable
        tag = "R10";
        wr_at(11, 'h42);
        cyc(0, 0, 0, 0, 0, 0, 1);
        cyc(0, 0, 0, 0);
        rd_at(12); cyc(0, 0, 0, 0);
        wr_at(11, 'h02);
        cyc(0, 0, 0, 0, 0, 0, 1);
        cyc(0, 0, 0, 0);
        rd_at(12);

        // R11: reset after enables and flags were set
        tag = "R11";
        wr_at(11, 'h7A); wr_at(10, 'h2F);
        cyc(0, 0, 0, 0, 0, 0, 1);
        cyc(0, 0, 0, 0, 1, 0, 0);
        do_reset(2);
        cyc(0, 0, 0, 0);
        get();
        rd_at(10); rd_at(11); rd_at(12); rd_at(13);
        rd_at(0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule